// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block holds the modem-line side of a byte-wide serial port: a five-bit control register that drives the four outgoing handshake lines, and a status register that tracks the four incoming handshake lines. Each incoming line passes through a synchronizer. The status register keeps the present level of every line in its upper half and a sticky change flag for every line in its lower half. Reading the status register returns the whole byte and clears the change flags. A single change-pending output, the OR of the four flags, goes to the interrupt logic.

A loopback test mode is selected by a control bit. In this mode the outgoing lines are held inactive, the incoming lines are ignored, and a status read shows the control bits instead of the line levels. Software reaches both registers through a simple one-cycle read/write port with a one-bit register select. Read data is registered and appears the cycle after the read strobe.

Top module: `modem_ctl_stat`

## Requirements
- R1: Each incoming line (cts_i, dsr_i, dcd_i, ri_i) passes through a two-flop synchronizer. A level presented before a clock edge is reflected in the status register after the third rising edge.
- R2: Status byte layout: bit 7 carrier detect, bit 6 ring, bit 5 data-set-ready, bit 4 clear-to-send, bit 3 carrier change, bit 2 ring trailing edge, bit 1 data-set-ready change, bit 0 clear-to-send change. A change in either direction of carrier, data-set-ready or clear-to-send sets its change bit, and the bit stays set until a status read clears it.
- R3: The ring change bit sets only when the ring level goes from 1 to 0. A 0-to-1 transition leaves it clear.
- R4: A status read (reg_sel=1, rd_en=1) returns the full byte on rd_data one cycle later and clears the four change bits. A change detected in that same cycle is kept.
- R5: The control register (reg_sel=0) stores only write-data bits 4:0. Bit 0 is DTR, bit 1 is RTS, bit 2 is OUT1, bit 3 is OUT2 and bit 4 is loopback. A control read returns zeros in bits 7:5.
- R6: msc_irq is high exactly while at least one stored change bit is set.
- R7: After reset the status register reads 0xB0 and the control register reads 0x08.
- R8: Outside loopback, dtr_o, rts_o, out1_o and out2_o equal control bits 0, 1, 2 and 3, from the cycle after the write.
- R9: In loopback, a status read returns OUT2 in bit 7, OUT1 in bit 6, DTR in bit 5 and RTS in bit 4, with bits 3:0 zero.
- R10: In loopback, all four outgoing lines are driven low. Incoming line changes neither update the stored levels nor set change bits, and status reads leave the stored change bits untouched. After loopback ends, the stored levels catch up and flag any difference.
- R11: A write with reg_sel=1 has no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |
| cts_i | input | 1 | Incoming clear-to-send level |
| dsr_i | input | 1 | Incoming data-set-ready level |
| dcd_i | input | 1 | Incoming carrier-detect level |
| ri_i | input | 1 | Incoming ring level |
| dtr_o | output | 1 | Outgoing data-terminal-ready |
| rts_o | output | 1 | Outgoing request-to-send |
| out1_o | output | 1 | Outgoing user line 1 |
| out2_o | output | 1 | Outgoing user line 2 |
| msc_irq | output | 1 | Modem status change pending |

## Verification
The stimulus drops a single line, which separates a correct delta from a stuck or misplaced bit. It then raises and lowers the ring line, which distinguishes trailing-edge detection from plain XOR detection. Two lines then fall together to confirm that the change bits are independent. A quick up-then-down pulse checks that a change flag stays set after the level has returned. The control stimulus writes values with the upper bits set, to show the masking. It steps through loopback with different control patterns, which exposes wrong remapping, outgoing lines that leak through, and a frozen level that fails to catch up on exit.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int LINES  = 4;
    localparam int CTL_W  = 5;
    localparam int BYTE_W = 8;

    // line index inside a nibble: 3 carrier, 2 ring, 1 dsr, 0 cts
    localparam int IX_CTS = 0;
    localparam int IX_DSR = 1;
    localparam int IX_RI  = 2;
    localparam int IX_DCD = 3;

    // control bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OUT1 = 2;
    localparam int CB_OUT2 = 3;
    localparam int CB_LOOP = 4;

    localparam logic [LINES-1:0] LVL_RST = 4'b1011;
    localparam logic [CTL_W-1:0] CTL_RST = 5'b01000;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [LINES-1:0]  lvl;
        logic [LINES-1:0]  dlt;
        logic [BYTE_W-1:0] rdat;
    } mdm_state_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int                 WIDTH   = 4,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_edge.sv
module mdm_edge
    import mdm_pkg::*;
(
    input  logic [LINES-1:0] old_lvl,
    input  logic [LINES-1:0] new_lvl,
    output logic [LINES-1:0] set_mask
);
    always_comb begin
        set_mask = old_lvl ^ new_lvl;
        // ring flags only a falling level
        set_mask[IX_RI] = old_lvl[IX_RI] & ~new_lvl[IX_RI];
    end
endmodule

// File: rtl/mdm_loopmap.sv
module mdm_loopmap
    import mdm_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    output logic [LINES-1:0] lb_lvl
);
    always_comb begin
        lb_lvl         = '0;
        lb_lvl[IX_DCD] = ctl[CB_OUT2];
        lb_lvl[IX_RI]  = ctl[CB_OUT1];
        lb_lvl[IX_DSR] = ctl[CB_DTR];
        lb_lvl[IX_CTS] = ctl[CB_RTS];
    end
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              cts_i,
    input  logic              dsr_i,
    input  logic              dcd_i,
    input  logic              ri_i,
    output logic              dtr_o,
    output logic              rts_o,
    output logic              out1_o,
    output logic              out2_o,
    output logic              msc_irq
);
    localparam int PAD_W = BYTE_W - CTL_W;

    mdm_state_t st_d, st_q;
    logic [LINES-1:0] raw_lvl, sync_lvl, set_mask, lb_lvl;
    logic             loop_on, stat_clr;
    logic [PAD_W-1:0] unused_wr_hi;

    assign unused_wr_hi = wr_data[BYTE_W-1:CTL_W];

    always_comb begin
        raw_lvl         = '0;
        raw_lvl[IX_CTS] = cts_i;
        raw_lvl[IX_DSR] = dsr_i;
        raw_lvl[IX_RI]  = ri_i;
        raw_lvl[IX_DCD] = dcd_i;
    end

    mdm_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LVL_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_lvl), .dout(sync_lvl)
    );

    mdm_edge u_edge (.old_lvl(st_q.lvl), .new_lvl(sync_lvl), .set_mask(set_mask));

    mdm_loopmap u_loop (.ctl(st_q.ctl), .lb_lvl(lb_lvl));

    assign loop_on  = st_q.ctl[CB_LOOP];
    assign stat_clr = rd_en && reg_sel && !loop_on;

    always_comb begin
        st_d = st_q;
        if (!loop_on) begin
            st_d.lvl = sync_lvl;
        end
        st_d.dlt = (stat_clr ? '0 : st_q.dlt) | (loop_on ? '0 : set_mask);
        if (wr_en && !reg_sel) begin
            st_d.ctl = wr_data[CTL_W-1:0];
        end
        if (rd_en) begin
            if (!reg_sel)     st_d.rdat = {{PAD_W{1'b0}}, st_q.ctl};
            else if (loop_on) st_d.rdat = {lb_lvl, {LINES{1'b0}}};
            else              st_d.rdat = {st_q.lvl, st_q.dlt};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl  <= CTL_RST;
            st_q.lvl  <= LVL_RST;
            st_q.dlt  <= '0;
            st_q.rdat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdat;
    assign dtr_o   = st_q.ctl[CB_DTR]  & ~loop_on;
    assign rts_o   = st_q.ctl[CB_RTS]  & ~loop_on;
    assign out1_o  = st_q.ctl[CB_OUT1] & ~loop_on;
    assign out2_o  = st_q.ctl[CB_OUT2] & ~loop_on;
    assign msc_irq = |st_q.dlt;
endmodule

// File: rtl/mdm_chk.sv
module mdm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_sel,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic [4:0] ctl_q,
    input logic [3:0] lvl_q,
    input logic [3:0] dlt_q,
    input logic       dtr_o,
    input logic       rts_o,
    input logic       out1_o,
    input logic       out2_o
);
    // R2
    sticky_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && reg_sel && !ctl_q[4]) |=> ((dlt_q & $past(dlt_q)) == $past(dlt_q)));

    // R3
    ring_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_q[2]) |-> !$rose(dlt_q[2]));

    // R5
    ctl_read_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !reg_sel) |=> (rd_data[7:5] == 3'b000));

    // R9
    loop_read_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel && ctl_q[4]) |=> (rd_data[3:0] == 4'h0));

    // R10
    loop_lines_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] |-> !(dtr_o || rts_o || out1_o || out2_o));

    // R10
    loop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[4] && $past(ctl_q[4])) |-> $stable(lvl_q));
endmodule

bind modem_ctl_stat mdm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en),
    .rd_data(rd_data), .ctl_q(st_q.ctl), .lvl_q(st_q.lvl), .dlt_q(st_q.dlt),
    .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o)
);

// File: tb/modem_ctl_stat_tb.sv
module modem_ctl_stat_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic cts_i = 1'b1, dsr_i = 1'b1, dcd_i = 1'b1, ri_i = 1'b0;
    logic dtr_o, rts_o, out1_o, out2_o, msc_irq;

    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    modem_ctl_stat u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .cts_i(cts_i), .dsr_i(dsr_i),
        .dcd_i(dcd_i), .ri_i(ri_i), .dtr_o(dtr_o), .rts_o(rts_o),
        .out1_o(out1_o), .out2_o(out2_o), .msc_irq(msc_irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completed read
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic reg_read(input logic sel, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_sel = sel; rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] val);
        @(negedge clk);
        reg_sel = sel; wr_en = 1'b1; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_lines(input string tag, input logic [3:0] exp);
        check(tag, {4'h0, out2_o, out1_o, rts_o, dtr_o}, {4'h0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R7 reset values
        reg_read(1'b1, 8'hB0, "R7 status reset");
        reg_read(1'b0, 8'h08, "R7 control reset");
        @(negedge clk);
        chk_lines("R8 reset lines", 4'b1000);
        check("R6 irq idle", {7'h0, msc_irq}, 8'h00);

        // R1 R2 single line drop
        @(negedge clk); cts_i = 1'b0;
        settle();
        check("R6 irq after cts change", {7'h0, msc_irq}, 8'h01);
        reg_read(1'b1, 8'hA1, "R1 R2 cts drop");
        reg_read(1'b1, 8'hA0, "R4 deltas cleared");
        @(negedge clk);
        check("R6 irq cleared", {7'h0, msc_irq}, 8'h00);

        // R3 ring rise then fall
        @(negedge clk); ri_i = 1'b1;
        settle();
        check("R3 irq on ring rise", {7'h0, msc_irq}, 8'h00);
        reg_read(1'b1, 8'hE0, "R3 ring rise no flag");
        @(negedge clk); ri_i = 1'b0;
        settle();
        reg_read(1'b1, 8'hA4, "R3 ring fall flag");

        // R2 two lines at once
        @(negedge clk); dsr_i = 1'b0; dcd_i = 1'b0;
        settle();
        reg_read(1'b1, 8'h0A, "R2 dsr and dcd drop");
        reg_read(1'b1, 8'h00, "R4 cleared again");

        // R2 sticky after pulse
        @(negedge clk); cts_i = 1'b1;
        settle();
        @(negedge clk); cts_i = 1'b0;
        settle();
        reg_read(1'b1, 8'h01, "R2 sticky after pulse");
        reg_read(1'b1, 8'h00, "R4 pulse cleared");

        // R5 R8 control
        reg_write(1'b0, 8'hEF);
        chk_lines("R8 lines follow control", 4'b1111);
        reg_read(1'b0, 8'h0F, "R5 control masked");

        // R9 R10 loopback
        reg_write(1'b0, 8'h15);
        chk_lines("R10 lines low in loop", 4'b0000);
        reg_read(1'b0, 8'h15, "R5 loop control readback");
        reg_read(1'b1, 8'h60, "R9 loop map out1 dtr");
        @(negedge clk); cts_i = 1'b1;
        settle();
        check("R10 irq frozen in loop", {7'h0, msc_irq}, 8'h00);
        reg_read(1'b1, 8'h60, "R10 input ignored in loop");
        reg_write(1'b0, 8'h1A);
        reg_read(1'b1, 8'h90, "R9 loop map out2 rts");
        reg_write(1'b0, 8'h00);
        chk_lines("R8 lines after loop exit", 4'b0000);
        settle();
        reg_read(1'b1, 8'h11, "R10 catch up after loop");
        reg_read(1'b1, 8'h10, "R4 catch up cleared");

        // R11 status write ignored
        reg_write(1'b1, 8'hFF);
        reg_read(1'b1, 8'h10, "R11 status write ignored");
        reg_read(1'b0, 8'h00, "R11 control untouched");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule